// File: doc/BRIEF.md
# SPI Burst Master

This block is a serial peripheral interface master that moves one or two data words per transfer over a clock, a data-out line and a data-in line, and drives two slave-select outputs. Software reaches it through a plain register bus: a 6-bit byte address, a write strobe, 32-bit write data and combinational read data. Five registers hold control and status, the serial clock divider, the slave-select setup and the two data words.

The clock idle level, the clock edge that launches data and the edge that samples it, the word length (1 to 32 bits), the bit order and a byte reversal are all set at run time. A two-word burst inserts a programmable pause between its words. Each data word lives in a single register that serves both directions: the bits shifted in replace the bits shifted out. A sticky completion flag drives an interrupt output when it is enabled. Slave-select lines are either held by software or asserted by the engine only while a transfer runs.

Top module: `spi_burst_master`

## Requirements
- R1: A bus write to the control register (address 0x00) with bit 0 set starts a transfer. Bit 0 reads 1 while the transfer runs and 0 once it has ended. A control write with bit 0 clear starts nothing.
- R2: While a transfer runs, bus writes to every address are dropped. The divider, the data words, the slave-select setup and the control fields read back unchanged afterwards.
- R3: Control bit 11 sets the idle level of SCLK (0 low, 1 high). During a word each SCLK half period lasts DIV+1 clock cycles, where DIV is bits 15:0 of the register at 0x04.
- R4: Control bit 2 picks the SCLK edge that changes MOSI and control bit 1 picks the edge that samples MISO (0 rising, 1 falling). Bit k of a word is valid on MOSI at the bit-k edge of the opposite type.
- R5: Control bits 7:3 set the word length N in bits, with 0 meaning 32. A received word fills bits N-1:0 and clears the bits above.
- R6: With control bit 10 clear, bit N-1 goes out first and the first bit received lands in bit N-1. With it set, bit 0 goes out first and the first bit received lands in bit 0.
- R7: Control bits 9:8 equal to 1 make a transfer send word 0 and then word 1. Any other code sends word 0 only.
- R8: In a burst, the interval from the last SCLK edge of word 0 to the first SCLK edge of word 1 is (2*(G+2)+1)*(DIV+1) clock cycles, where G is control bits 15:12. That is G+2 SCLK periods plus one half period.
- R9: Word 0 reads at 0x10 and 0x20, and word 1 reads at 0x14 and 0x24. A write to either address of a word replaces it. A received word replaces the sent one, so a later transfer with no write in between sends the received data.
- R10: Control bit 16 becomes 1 when a transfer ends and stays 1 until a control write with bit 16 set clears it. The irq output equals bit 16 AND control bit 17.
- R11: With control bit 20 set and N equal to 16, 24 or 32, the bytes of the N-bit word are reversed both on the way out and on the way in. For other lengths the bit has no effect.
- R12: The register at 0x08 holds select bits 1:0, an active level at bit 2 (0 low, 1 high) and an automatic flag at bit 3. Output ss_o[i] is active when select bit i is set and, in automatic mode, only while a transfer runs. Otherwise it sits at the inactive level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Register byte address |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from bus_addr |
| irq | output | 1 | Completion interrupt |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_o | output | 2 | Slave-select outputs |

## Verification
The hardest case to reach is a configuration in which the launch and sample edges fall on the same SCLK edge, or in which the first edge launches data. There the first MOSI bit has to be presented before any edge, and a received bit must not overwrite a bit that is still being sent. The bench drives a slave model from its own edge count. It captures MOSI on the edge opposite the launch edge and supplies MISO ahead of the sample edge, and it covers the trailing-launch, leading-launch and same-edge cases with both idle levels. The suspend interval is measured in clock cycles between the last edge of word 0 and the first edge of word 1. Dropped writes are exercised by issuing writes to every register between the start and the end of a transfer.

// File: rtl/spi_burst_master.sv
module spi_burst_master #(
  parameter int DIVW = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  bus_addr,
  input  logic        bus_we,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic [1:0]  ss_o
);
  localparam logic [31:0] WMASK = 32'h0012_FFFE;

  typedef enum logic [1:0] {IDLE, SHIFT, GAP} st_t;
  st_t st;

  logic [31:0]       ctrl;
  logic [DIVW-1:0]   div, dcnt;
  logic [3:0]        ssr;
  logic [1:0][31:0]  data;
  logic [31:0]       rsh, rsh_n;
  logic [6:0]        hcnt;
  logic [5:0]        gcnt;
  logic              done, wsel, ph;

  function automatic logic [31:0] bswap(input logic [31:0] v, input logic [5:0] n);
    case (n)
      6'd16:   return {16'b0, v[7:0], v[15:8]};
      6'd24:   return {8'b0, v[7:0], v[15:8], v[23:16]};
      6'd32:   return {v[7:0], v[15:8], v[23:16], v[31:24]};
      default: return v;
    endcase
  endfunction

  wire        busy    = st != IDLE;
  wire        tick    = busy && dcnt == div;
  wire [3:0]  wa      = bus_addr[5:2];
  wire        wr      = bus_we && !busy && bus_addr[1:0] == 2'b00;
  wire [5:0]  nbits   = ctrl[7:3] == 5'd0 ? 6'd32 : {1'b0, ctrl[7:3]};
  wire [4:0]  nm1     = 5'(nbits - 6'd1);
  wire        tx_lead = ctrl[2] == ctrl[11];
  wire        rx_lead = ctrl[1] == ctrl[11];
  wire        lead    = ~hcnt[0];
  wire        last    = hcnt == 7'({nbits, 1'b0} - 7'd1);
  wire [4:0]  tidx    = !tx_lead ? hcnt[5:1] :
                        (hcnt == 7'd0 ? 5'd0 : 5'((hcnt - 7'd1) >> 1));
  wire [4:0]  tpos    = ctrl[10] ? tidx : nm1 - tidx;
  wire [4:0]  rpos    = ctrl[10] ? hcnt[5:1] : nm1 - hcnt[5:1];
  wire [31:0] txw     = ctrl[20] ? bswap(data[wsel], nbits) : data[wsel];
  wire [31:0] rxw     = ctrl[20] ? bswap(rsh_n, nbits) : rsh_n;
  wire [5:0]  gap_end = {1'b0, ctrl[15:12], 1'b0} + 6'd3;
  wire [1:0]  ss_act  = ssr[1:0] & {2{~ssr[3] | busy}};

  always_comb begin
    rsh_n = rsh;
    if (st == SHIFT && tick && lead == rx_lead) rsh_n[rpos] = miso;
  end

  assign sclk = ph ^ ctrl[11];
  assign mosi = busy & txw[tpos];
  assign irq  = done & ctrl[17];
  assign ss_o = ssr[2] ? ss_act : ~ss_act;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr[1:0] == 2'b00)
      case (wa)
        4'h0:       bus_rdata = ctrl | {15'b0, done, 15'b0, busy};
        4'h1:       bus_rdata = 32'(div);
        4'h2:       bus_rdata = {28'b0, ssr};
        4'h4, 4'h8: bus_rdata = data[0];
        4'h5, 4'h9: bus_rdata = data[1];
        default:    bus_rdata = '0;
      endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; ctrl <= '0; div <= '0; dcnt <= '0; ssr <= '0; data <= '0;
      rsh <= '0; hcnt <= '0; gcnt <= '0; done <= 1'b0; wsel <= 1'b0; ph <= 1'b0;
    end else begin
      if (wr)
        case (wa)
          4'h0: begin
            ctrl <= bus_wdata & WMASK;
            if (bus_wdata[16]) done <= 1'b0;
            if (bus_wdata[0]) begin
              st <= SHIFT; wsel <= 1'b0; hcnt <= '0; dcnt <= '0; rsh <= '0; ph <= 1'b0;
            end
          end
          4'h1:       div <= bus_wdata[DIVW-1:0];
          4'h2:       ssr <= bus_wdata[3:0];
          4'h4, 4'h8: data[0] <= bus_wdata;
          4'h5, 4'h9: data[1] <= bus_wdata;
          default: ;
        endcase
      if (busy) begin
        dcnt <= tick ? '0 : DIVW'(dcnt + 1'b1);
        if (tick)
          case (st)
            SHIFT: begin
              ph   <= ~ph;
              rsh  <= rsh_n;
              hcnt <= hcnt + 7'd1;
              if (last) begin
                data[wsel] <= rxw;
                hcnt <= '0;
                rsh  <= '0;
                if (!wsel && ctrl[9:8] == 2'b01) begin
                  st <= GAP; gcnt <= '0; wsel <= 1'b1;
                end else begin
                  st <= IDLE; done <= 1'b1;
                end
              end
            end
            GAP: begin
              gcnt <= gcnt + 6'd1;
              if (gcnt == gap_end) st <= SHIFT;
            end
            default: ;
          endcase
      end
    end
  end
endmodule

module spi_burst_master_chk #(
  parameter int DIVW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [3:0]      wa,
  input logic            we,
  input logic            wd0,
  input logic            wd16,
  input logic            sclk,
  input logic [1:0]      ss_o,
  input logic            busy,
  input logic            idle_hi,
  input logic [DIVW-1:0] div,
  input logic            done,
  input logic            irq,
  input logic            ss_auto,
  input logic            ss_lvl
);
  a_r1_start_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(we && wa == 4'h0 && wd0));

  a_r2_div_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> $stable(div));

  a_r3_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk == idle_hi);

  a_r10_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(done) && !$past(we && !busy && wa == 4'h0 && wd16) |-> done);

  a_r10_irq_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done);

  a_r12_auto_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && ss_auto |-> ss_o == {2{~ss_lvl}});
endmodule

bind spi_burst_master spi_burst_master_chk #(.DIVW(DIVW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wa(bus_addr[5:2]), .we(bus_we), .wd0(bus_wdata[0]),
  .wd16(bus_wdata[16]), .sclk(sclk), .ss_o(ss_o), .busy(busy), .idle_hi(ctrl[11]),
  .div(div), .done(done), .irq(irq), .ss_auto(ssr[3]), .ss_lvl(ssr[2])
);

// File: tb/spi_burst_master_test.sv
module spi_burst_master_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, sclk, mosi;
  logic        miso = 1'b0;
  logic [1:0]  ss_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_burst_master uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso), .ss_o(ss_o)
  );

  int n_run = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  logic [31:0] slv_q[$];
  logic [31:0] m_data[2];
  logic [31:0] sw = '0;
  int    g_n = 8, g_half = 1, wc = 0, gap_seen = 0;
  bit    g_txlead = 1'b0, g_rxlead = 1'b0, g_active = 1'b0;
  string g_tag = "";

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] bswap(input logic [31:0] v, input int n);
    if (n == 16) return {16'b0, v[7:0], v[15:8]};
    if (n == 24) return {8'b0, v[7:0], v[15:8], v[23:16]};
    if (n == 32) return {v[7:0], v[15:8], v[23:16], v[31:24]};
    return v;
  endfunction

  function automatic logic [31:0] to_wire(input logic [31:0] v, input int n, input bit lsb, input bit swp);
    logic [31:0] t = swp ? bswap(v, n) : v;
    logic [31:0] w = '0;
    for (int k = 0; k < n; k++) w[k] = t[lsb ? k : n-1-k];
    return w;
  endfunction

  function automatic logic [31:0] from_wire(input logic [31:0] w, input int n, input bit lsb, input bit swp);
    logic [31:0] r = '0;
    for (int k = 0; k < n; k++) r[lsb ? k : n-1-k] = w[k];
    return swp ? bswap(r, n) : r;
  endfunction

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // monitor: counts SCLK edges, captures MOSI, feeds MISO, pops expected words
  initial begin
    logic psclk, pmosi;
    logic [31:0] cap;
    int e, cyc, last_edge, last_end, k;
    psclk = 1'b0; pmosi = 1'b0; cap = '0; e = 0; cyc = 0; last_edge = 0; last_end = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (g_active && rst_n && sclk !== psclk) begin
        if (e > 0) check({g_tag, " R3 half period"}, cyc - last_edge, g_half);
        else if (wc == 1) gap_seen = cyc - last_end;
        if ((e % 2 == 1) == g_txlead) cap[e/2] = pmosi;
        last_edge = cyc;
        e++;
        if (e == 2*g_n) begin
          if (exp_q.size() == 0) check({g_tag, " R7 unexpected word"}, 1, 0);
          else check({g_tag, " R4 mosi bits"}, cap, exp_q.pop_front());
          e = 0; cap = '0; wc++; last_end = cyc;
          if (slv_q.size() > 0) begin sw = slv_q.pop_front(); miso = sw[0]; end
        end else begin
          k = g_rxlead ? (e+1)/2 : e/2;
          if (k < g_n) miso = sw[k];
        end
      end
      psclk = sclk; pmosi = mosi;
    end
  end

  // driver: configures, pushes expected wire words, runs one transfer, checks results
  task automatic xfer(input string tag, input logic [31:0] ctl, input bit wdat,
                      input logic [31:0] tx0, input logic [31:0] tx1,
                      input logic [31:0] s0, input logic [31:0] s1, input logic [15:0] dv,
                      input logic [1:0] ss_busy, input logic [1:0] ss_idle, input bit inject);
    logic [31:0] v;
    int n = (ctl[7:3] == 5'd0) ? 32 : int'(ctl[7:3]);
    int nw = (ctl[9:8] == 2'b01) ? 2 : 1;
    int guard = 0;
    bit lsb = ctl[10], swp = ctl[20];
    wr(6'h04, {16'b0, dv});
    if (wdat) begin
      wr(6'h20, tx0); m_data[0] = tx0;
      wr(6'h24, tx1); m_data[1] = tx1;
    end
    wr(6'h00, ctl);
    g_n = n; g_half = int'(dv) + 1; g_tag = tag; wc = 0;
    g_txlead = (ctl[2] == ctl[11]); g_rxlead = (ctl[1] == ctl[11]);
    for (int w = 0; w < nw; w++) exp_q.push_back(to_wire(m_data[w], n, lsb, swp));
    if (nw == 2) slv_q.push_back(s1);
    sw = s0; miso = s0[0];
    g_active = 1'b1;
    wr(6'h00, ctl | 32'h1);
    rd(6'h00, v);
    check({tag, " R1 busy while running"}, {31'b0, v[0]}, 32'h1);
    check({tag, " R12 select during transfer"}, {30'b0, ss_o}, {30'b0, ss_busy});
    if (inject) begin
      wr(6'h04, {16'b0, dv ^ 16'h0055});
      wr(6'h20, ~tx0);
      wr(6'h14, 32'h0000_1234);
      wr(6'h08, 32'h0);
      wr(6'h00, 32'h0001_0000);
    end
    do begin rd(6'h00, v); guard++; end while (v[0] && guard < 50000);
    g_active = 1'b0;
    m_data[0] = from_wire(s0, n, lsb, swp);
    if (nw == 2) m_data[1] = from_wire(s1, n, lsb, swp);
    rd(6'h10, v); check({tag, " R9 word0 received"}, v, m_data[0]);
    rd(6'h14, v); check({tag, " R9 word1 readback"}, v, m_data[1]);
    check({tag, " R7 all words sent"}, exp_q.size(), 0);
    rd(6'h00, v); check({tag, " R2 R10 control after end"}, v, ctl | 32'h0001_0000);
    rd(6'h04, v); check({tag, " R2 divider kept"}, v, {16'b0, dv});
    check({tag, " R12 select after transfer"}, {30'b0, ss_o}, {30'b0, ss_idle});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    m_data[0] = '0; m_data[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 R3 R12 reset state
    rd(6'h00, v); check("R1 reset control", v, 32'h0);
    check("R3 reset sclk idle low", {31'b0, sclk}, 32'h0);
    check("R12 reset select inactive", {30'b0, ss_o}, 32'h3);
    check("R10 reset irq", {31'b0, irq}, 32'h0);

    // R4 R6: 8-bit, MSB first, launch falling, sample rising, idle low; auto select ss0 low
    wr(6'h08, 32'h9);
    xfer("R4 R6 8b msb", (32'd8 << 3) | 32'h4, 1'b1, 32'hA5, 32'h0,
         32'h3C, 32'h0, 16'd1, 2'b10, 2'b11, 1'b0);

    // R3 R6 R12: 12-bit LSB first, idle high, launch rising, sample falling, manual active-high ss1
    wr(6'h08, 32'h6);
    xfer("R3 R6 12b lsb idle-high", (32'd12 << 3) | (32'd1 << 10) | (32'd1 << 11) | 32'h2, 1'b1,
         32'h0000_0ABC, 32'h0, 32'h0000_05A3, 32'h0, 16'd0, 2'b10, 2'b10, 1'b0);

    // R5: length code 0 means 32 bits, launch and sample on the same rising edge
    wr(6'h08, 32'hF);
    xfer("R5 32b same edge", 32'h0, 1'b1, 32'hDEAD_BEEF, 32'h0,
         32'h1234_5678, 32'h0, 16'd2, 2'b11, 2'b00, 1'b0);

    // R7 R8: two 16-bit words with suspend code 3
    wr(6'h08, 32'h9);
    xfer("R7 burst 16b", (32'd16 << 3) | (32'd1 << 8) | (32'd3 << 12) | 32'h4, 1'b1,
         32'h0000_1234, 32'h0000_BEEF, 32'h0000_0F0F, 32'h0000_8001, 16'd2, 2'b10, 2'b11, 1'b0);
    check("R8 suspend interval cycles", gap_seen, (2*(3+2)+1)*3);

    // R11: byte reversal at 24 bits, then at 32 bits with LSB first
    xfer("R11 swap 24b", (32'd24 << 3) | (32'd1 << 20) | 32'h4, 1'b1,
         32'h0011_2233, 32'h0, 32'h00A1_B2C3, 32'h0, 16'd1, 2'b10, 2'b11, 1'b0);
    xfer("R11 swap 32b lsb", (32'd1 << 20) | (32'd1 << 10) | 32'h4, 1'b1,
         32'hCAFE_0102, 32'h0, 32'h8421_F00D, 32'h0, 16'd0, 2'b10, 2'b11, 1'b0);

    // R9: no rewrite, the received word is sent again
    xfer("R9 resend", (32'd8 << 3) | 32'h4, 1'b0, 32'h0, 32'h0,
         32'h00C3, 32'h0, 16'd1, 2'b10, 2'b11, 1'b0);

    // R9: a write to the receive address changes what is sent
    wr(6'h10, 32'h0000_005C); m_data[0] = 32'h0000_005C;
    rd(6'h20, v); check("R9 alias readback", v, 32'h0000_005C);
    xfer("R9 write via rx address", (32'd8 << 3) | 32'h4, 1'b0, 32'h0, 32'h0,
         32'h0011, 32'h0, 16'd1, 2'b10, 2'b11, 1'b0);

    // R2: writes to every register during a transfer are dropped
    xfer("R2 writes while busy", (32'd16 << 3) | 32'h4, 1'b1, 32'h0000_7E81, 32'h0,
         32'h0000_1FF8, 32'h0, 16'd3, 2'b10, 2'b11, 1'b1);
    rd(6'h08, v); check("R2 select register kept", v, 32'h9);

    // R10: sticky flag, enable gating, write-one clear
    check("R10 irq off while disabled", {31'b0, irq}, 32'h0);
    rd(6'h00, v); check("R10 flag set", {31'b0, v[16]}, 32'h1);
    wr(6'h00, 32'h0002_0000);
    check("R10 irq with enable", {31'b0, irq}, 32'h1);
    wr(6'h00, 32'h0003_0000);
    check("R10 irq after clear", {31'b0, irq}, 32'h0);
    rd(6'h00, v); check("R10 flag cleared", {31'b0, v[16]}, 32'h0);
    xfer("R10 end raises irq", (32'd8 << 3) | (32'd1 << 17) | 32'h4, 1'b1, 32'h0F, 32'h0,
         32'hF0, 32'h0, 16'd0, 2'b10, 2'b11, 1'b0);
    check("R10 irq after transfer", {31'b0, irq}, 32'h1);

    // R1 R3: writing with bit 0 clear starts nothing; idle level follows bit 11
    wr(6'h00, 32'h0001_0800);
    repeat (20) @(negedge clk);
    rd(6'h00, v); check("R1 no start on zero", v, 32'h0000_0800);
    check("R3 idle high", {31'b0, sclk}, 32'h1);
    check("R1 nothing sent", exp_q.size(), 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule